// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the hazard control for an in-order pipeline with five stages: fetch, decode, execute, memory access and writeback. Each cycle it looks at the two source register numbers of the instruction in decode. It also looks at the destination register, write enable, load flag and resolved-taken-branch flag of the instruction in execute, and at the destination register and write enable of the instruction in memory access. From these it decides how the next execute stage gets its operands, and whether the front of the pipeline must wait or be cleared.

The forwarding selects are computed one stage early, while the consumer is still in decode, and are held in a register. They are therefore valid, with no extra logic depth, during the cycle in which that instruction executes. The stall, bubble and flush controls are combinational, so the pipeline registers use them at the very next clock edge. A freeze input stops the whole pipeline. While it is high, the controller issues no control action and keeps its stored selects.

All pins are plain control signals. There is no data stream and so no valid/ready handshake. The surrounding pipeline must sample every control output at the clock edge that ends the cycle in which it is driven.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: The operand select is registered. One cycle after decode shows a source equal to a non-zero execute-stage destination whose write enable is high and whose load flag is low, that operand's select reads 2'b10 (take the memory-stage result).
- R2: One cycle after decode shows a source that matches a non-zero, write-enabled memory-stage destination and no eligible execute-stage writer, that operand's select reads 2'b01 (take the writeback result).
- R3: When both candidate producers match the same source, the select gives 2'b10, so the younger producer wins.
- R4: Register 0 is never forwarded and never causes a stall. A source of 0 gives select 2'b00 (register file).
- R5: A producer whose write enable is low is ignored for both forwarding and stalling.
- R6: A load in execute whose non-zero destination matches either decode source raises stall_o and bubble_o in that same cycle. Both selects read 2'b00 in the cycle after.
- R7: After a load-use stall, when the load has moved to memory access and the execute stage holds the bubble, the held consumer's select becomes 2'b01 in the next cycle.
- R8: A taken branch in execute raises flush_o in the same cycle, which clears the two younger instructions. Both selects read 2'b00 in the next cycle.
- R9: A flush overrides a load-use stall. When both apply, flush_o is 1 and stall_o and bubble_o are 0.
- R10: While freeze_i is high, stall_o, bubble_o and flush_o are 0 whatever the other inputs are, and both selects keep their previous values in the next cycle.
- R11: During and right after reset, stall_o, bubble_o and flush_o are 0 for idle inputs, and both selects read 2'b00.
- R12: A select never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| freeze_i | input | 1 | Global freeze: suppresses all actions and holds state |
| id_rs1_i | input | 5 | First source register of the decode-stage instruction |
| id_rs2_i | input | 5 | Second source register of the decode-stage instruction |
| ex_rd_i | input | 5 | Destination register of the execute-stage instruction |
| ex_wen_i | input | 1 | Execute-stage instruction writes a register |
| ex_load_i | input | 1 | Execute-stage instruction is a load |
| ex_br_taken_i | input | 1 | Branch in execute resolved as taken |
| mem_rd_i | input | 5 | Destination register of the memory-stage instruction |
| mem_wen_i | input | 1 | Memory-stage instruction writes a register |
| stall_o | output | 1 | Hold the program counter and the fetch/decode register |
| bubble_o | output | 1 | Load a no-op into the decode/execute register |
| flush_o | output | 1 | Clear the fetch/decode and decode/execute registers |
| fwd_a_o | output | 2 | First-operand select for execute: 00 register file, 01 writeback, 10 memory |
| fwd_b_o | output | 2 | Second-operand select for execute: same encoding |

## Verification
Stall, bubble and flush depend only on the current inputs. The bench drives inputs just after a falling edge and reads these three outputs two nanoseconds later, before the next rising edge. The operand selects pass through one register. They are read one nanosecond after the rising edge that follows the stimulus, and inputs are not changed in between. For freeze, the bench first checks that the selects kept the value stored before the frozen cycle, then releases freeze and checks that the updates resume.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int NUM_REGS = 32;
  localparam int REG_W    = $clog2(NUM_REGS);
  localparam int NUM_SRC  = 2;

  typedef enum logic [1:0] {
    FWD_REG = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match
  import hz_pkg::*;
#(
  parameter int RW = REG_W
) (
  input  logic [RW-1:0] src_i,
  input  logic [RW-1:0] near_rd_i,
  input  logic          near_ok_i,
  input  logic [RW-1:0] far_rd_i,
  input  logic          far_ok_i,
  output fwd_sel_e      sel_o
);
  logic src_live;
  logic near_hit;
  logic far_hit;

  assign src_live = (src_i != '0);
  assign near_hit = src_live && near_ok_i && (near_rd_i == src_i);
  assign far_hit  = src_live && far_ok_i && (far_rd_i == src_i);

  always_comb begin
    if (near_hit)     sel_o = FWD_MEM;
    else if (far_hit) sel_o = FWD_WB;
    else              sel_o = FWD_REG;
  end
endmodule

// File: rtl/hz_loaduse.sv
module hz_loaduse
  import hz_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int NS = NUM_SRC
) (
  input  logic [NS-1:0][RW-1:0] src_i,
  input  logic [RW-1:0]         ld_rd_i,
  input  logic                  ld_wen_i,
  input  logic                  ld_flag_i,
  output logic                  hit_o
);
  logic [NS-1:0] per_src;

  for (genvar g = 0; g < NS; g++) begin : g_cmp
    assign per_src[g] = (src_i[g] != '0) && (src_i[g] == ld_rd_i);
  end

  assign hit_o = ld_wen_i && ld_flag_i && (ld_rd_i != '0) && (|per_src);
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hz_pkg::*;
#(
  parameter int RW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          freeze_i,
  input  logic [RW-1:0] id_rs1_i,
  input  logic [RW-1:0] id_rs2_i,
  input  logic [RW-1:0] ex_rd_i,
  input  logic          ex_wen_i,
  input  logic          ex_load_i,
  input  logic          ex_br_taken_i,
  input  logic [RW-1:0] mem_rd_i,
  input  logic          mem_wen_i,
  output logic          stall_o,
  output logic          bubble_o,
  output logic          flush_o,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o
);
  localparam int NS = NUM_SRC;

  logic [NS-1:0][RW-1:0] src;
  fwd_sel_e              sel_next [NS];
  fwd_sel_e              sel_q    [NS];
  logic                  ld_hit;
  logic                  near_ok;
  logic                  clear_sel;

  assign src[0]  = id_rs1_i;
  assign src[1]  = id_rs2_i;
  // a load result is not ready in memory stage: such a hit stalls instead
  assign near_ok = ex_wen_i && !ex_load_i;

  for (genvar g = 0; g < NS; g++) begin : g_op
    hz_src_match #(.RW(RW)) u_match (
      .src_i     (src[g]),
      .near_rd_i (ex_rd_i),
      .near_ok_i (near_ok),
      .far_rd_i  (mem_rd_i),
      .far_ok_i  (mem_wen_i),
      .sel_o     (sel_next[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sel_q[g] <= FWD_REG;
      else if (!freeze_i) sel_q[g] <= clear_sel ? FWD_REG : sel_next[g];
    end
  end

  hz_loaduse #(.RW(RW), .NS(NS)) u_loaduse (
    .src_i     (src),
    .ld_rd_i   (ex_rd_i),
    .ld_wen_i  (ex_wen_i),
    .ld_flag_i (ex_load_i),
    .hit_o     (ld_hit)
  );

  // freeze masks everything; flush outranks the interlock
  always_comb begin
    flush_o  = !freeze_i && ex_br_taken_i;
    stall_o  = !freeze_i && !ex_br_taken_i && ld_hit;
    bubble_o = stall_o;
  end

  assign clear_sel = flush_o || bubble_o;
  assign fwd_a_o   = sel_q[0];
  assign fwd_b_o   = sel_q[1];
endmodule

// File: rtl/pipe_hazard_ctrl_checker.sv
module pipe_hazard_ctrl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       freeze_i,
  input logic [4:0] id_rs1_i,
  input logic [4:0] id_rs2_i,
  input logic       stall_o,
  input logic       bubble_o,
  input logic       flush_o,
  input logic [1:0] fwd_a_o,
  input logic [1:0] fwd_b_o
);
  assert_flush_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (!stall_o && !bubble_o));

  assert_freeze_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i |-> (!stall_o && !bubble_o && !flush_o));

  assert_freeze_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i |=> ($stable(fwd_a_o) && $stable(fwd_b_o)));

  assert_stall_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> bubble_o);

  assert_bubble_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_o |=> (fwd_a_o == 2'b00 && fwd_b_o == 2'b00));

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> (fwd_a_o == 2'b00 && fwd_b_o == 2'b00));

  assert_zero_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze_i && id_rs1_i == 5'd0) |=> (fwd_a_o == 2'b00));

  assert_no_bad_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a_o != 2'b11 && fwd_b_o != 2'b11));
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .freeze_i (freeze_i),
  .id_rs1_i (id_rs1_i),
  .id_rs2_i (id_rs2_i),
  .stall_o  (stall_o),
  .bubble_o (bubble_o),
  .flush_o  (flush_o),
  .fwd_a_o  (fwd_a_o),
  .fwd_b_o  (fwd_b_o)
);

// File: tb/pipe_hazard_ctrl_bench.sv
module pipe_hazard_ctrl_bench;
  typedef struct packed {
    logic [4:0] rs1, rs2, exrd;
    logic       exwen, exld, br;
    logic [4:0] memrd;
    logic       memwen;
    logic       stall, bubble, flush;
    logic [1:0] fa, fb;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{5'd1,  5'd2,  5'd1,  1'b1, 1'b0, 1'b0, 5'd2,  1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd1}, // R1 R2
    '{5'd3,  5'd3,  5'd3,  1'b1, 1'b0, 1'b0, 5'd3,  1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd2}, // R3
    '{5'd0,  5'd0,  5'd0,  1'b1, 1'b0, 1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0}, // R4
    '{5'd4,  5'd5,  5'd4,  1'b0, 1'b0, 1'b0, 5'd5,  1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0}, // R5
    '{5'd4,  5'd0,  5'd4,  1'b0, 1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0}, // R5 load, no write
    '{5'd6,  5'd7,  5'd6,  1'b1, 1'b1, 1'b0, 5'd9,  1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0}, // R6
    '{5'd6,  5'd7,  5'd0,  1'b0, 1'b0, 1'b0, 5'd6,  1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0}, // R7
    '{5'd8,  5'd7,  5'd6,  1'b1, 1'b1, 1'b0, 5'd7,  1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1}, // R2 load elsewhere
    '{5'd6,  5'd7,  5'd6,  1'b1, 1'b1, 1'b1, 5'd7,  1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0}, // R9
    '{5'd1,  5'd2,  5'd1,  1'b1, 1'b0, 1'b1, 5'd2,  1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0}, // R8
    '{5'd12, 5'd0,  5'd12, 1'b1, 1'b0, 1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0}  // R1 R4
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       freeze_i = 1'b0;
  logic [4:0] id_rs1_i = '0, id_rs2_i = '0, ex_rd_i = '0, mem_rd_i = '0;
  logic       ex_wen_i = 1'b0, ex_load_i = 1'b0, ex_br_taken_i = 1'b0, mem_wen_i = 1'b0;
  logic       stall_o, bubble_o, flush_o;
  logic [1:0] fwd_a_o, fwd_b_o;
  int         total = 0;
  int         bad = 0;

  always #5 clk = ~clk;

  pipe_hazard_ctrl u_pipe_hazard_ctrl (
    .clk(clk), .rst_n(rst_n), .freeze_i(freeze_i),
    .id_rs1_i(id_rs1_i), .id_rs2_i(id_rs2_i),
    .ex_rd_i(ex_rd_i), .ex_wen_i(ex_wen_i), .ex_load_i(ex_load_i),
    .ex_br_taken_i(ex_br_taken_i), .mem_rd_i(mem_rd_i), .mem_wen_i(mem_wen_i),
    .stall_o(stall_o), .bubble_o(bubble_o), .flush_o(flush_o),
    .fwd_a_o(fwd_a_o), .fwd_b_o(fwd_b_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    id_rs1_i = v.rs1; id_rs2_i = v.rs2; ex_rd_i = v.exrd;
    ex_wen_i = v.exwen; ex_load_i = v.exld; ex_br_taken_i = v.br;
    mem_rd_i = v.memrd; mem_wen_i = v.memwen;
  endtask

  task automatic run_vec(input vec_t v, input string req);
    @(negedge clk);
    drive(v);
    #2;
    check(req, "stall", int'(stall_o), int'(v.stall));
    check(req, "bubble", int'(bubble_o), int'(v.bubble));
    check(req, "flush", int'(flush_o), int'(v.flush));
    @(posedge clk);
    #1;
    check(req, "fwd_a", int'(fwd_a_o), int'(v.fa));
    check(req, "fwd_b", int'(fwd_b_o), int'(v.fb));
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    // R11: reset state
    repeat (2) @(negedge clk);
    check("R11", "stall in reset", int'(stall_o), 0);
    check("R11", "fwd_a in reset", int'(fwd_a_o), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R11", "fwd_b after reset", int'(fwd_b_o), 0);
    check("R11", "flush after reset", int'(flush_o), 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], $sformatf("vec%0d", i));

    // R10: store a select, then freeze with stall- and flush-provoking inputs
    run_vec(VEC[0], "R10 setup");
    @(negedge clk);
    freeze_i = 1'b1;
    drive(VEC[5]);
    #2;
    check("R10", "stall frozen", int'(stall_o), 0);
    check("R10", "bubble frozen", int'(bubble_o), 0);
    @(posedge clk); #1;
    check("R10", "fwd_a held", int'(fwd_a_o), 2);
    check("R10", "fwd_b held", int'(fwd_b_o), 1);
    @(negedge clk);
    drive(VEC[9]);
    #2;
    check("R10", "flush frozen", int'(flush_o), 0);
    @(posedge clk); #1;
    check("R10", "fwd_a still held", int'(fwd_a_o), 2);
    @(negedge clk);
    freeze_i = 1'b0;
    run_vec(VEC[2], "R10 release");

    // R12: walk all select-producing patterns, no 2'b11 code
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      id_rs1_i = 5'd5; id_rs2_i = 5'd5;
      ex_rd_i = 5'd5; ex_wen_i = k[0]; ex_load_i = 1'b0; ex_br_taken_i = 1'b0;
      mem_rd_i = 5'd5; mem_wen_i = k[1];
      @(posedge clk); #1;
      check("R12", "fwd_a code", int'(fwd_a_o == 2'b11), 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule